// File: doc/BRIEF.md
# Off-State Open-Load Qualifier

This block decides whether a high-side output channel has lost its load. It does this only while the channel is commanded off. An analog comparator, which is outside this block, raises a digital flag when the off-state output voltage climbs above the open-load threshold. That flag is not trusted at once. It must stay high, with the channel still commanded off, for longer than a programmable blanking interval before a fault is reported. The interval is counted in clock ticks. This filtering hides the ringing that follows the demagnetization of an inductive load.

The qualified fault drops on the clock edge after the comparator flag falls, which means the load has reconnected. It also drops on the clock edge after the channel is commanded on. The block also produces the shared active-low diagnostic line. That line goes low whenever the open-load fault, an external cut-off fault or an external thermal fault is present.

Top module: `ol_blank_qual`

## Requirements
- R1: While `rst_n` is low, `ol_fault` is 0 and the internal tick count is cleared. With `cutoff_flt` and `thermal_flt` low, `diag_n` is 1.
- R2: A condition tick is a rising clock edge at which `cmd_on`=0 and `ol_cmp`=1. With `blank_ticks`=N, `ol_fault` becomes 1 right after the (N+1)-th consecutive condition tick. It stays 0 after ticks 1 to N.
- R3: A rising edge at which `ol_cmp`=0 restarts the count. After it, a fresh run of N+1 consecutive condition ticks is needed before the fault is reported.
- R4: A rising edge at which `cmd_on`=1 clears `ol_fault` and restarts the count. While `cmd_on`=1, `ol_cmp` has no effect.
- R5: With `cmd_on`=0, a rising edge at which `ol_cmp`=0 clears `ol_fault`.
- R6: With `blank_ticks`=0, `ol_fault` becomes 1 right after the first condition tick.
- R7: `diag_n` is combinational and active low: it is 0 exactly when at least one of `ol_fault`, `cutoff_flt` or `thermal_flt` is 1.
- R8: After a high-to-low transition of `cmd_on`, the blanking count starts from zero, even if `ol_cmp` was high while the channel was on.
- R9: If `blank_ticks` is lowered to a value at or below the number of condition ticks already counted, the next condition tick sets `ol_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Channel command, 1 = output on |
| ol_cmp | input | 1 | Comparator flag, 1 = off-state output above open-load threshold |
| blank_ticks | input | CNT_W | Blanking length in ticks |
| cutoff_flt | input | 1 | Cut-off fault from the current-limit logic |
| thermal_flt | input | 1 | Thermal-shutdown fault |
| ol_fault | output | 1 | Qualified open-load fault |
| diag_n | output | 1 | Shared diagnostic, active low |

## Verification
The bench checks the exact tick at which the fault rises. An off-by-one design would report after N ticks instead of N+1, or one tick late. It drops the comparator flag one tick before qualification. A design that paused its count instead of restarting would then report too early. It holds the comparator high while the channel is on and then releases the command. A design that counted during the on-state would report at once when the command goes low. The bench also lowers the blanking length below the running count, which catches an equality-only compare that would never fire. Last, it drives each external fault alone to prove the diagnostic NOR.

// File: rtl/ol_blank_qual.sv
module ol_blank_qual #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_on,
  input  logic             ol_cmp,
  input  logic [CNT_W-1:0] blank_ticks,
  input  logic             cutoff_flt,
  input  logic             thermal_flt,
  output logic             ol_fault,
  output logic             diag_n
);

  logic             cond;
  logic [CNT_W-1:0] cnt;

  assign cond = ~cmd_on & ol_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ol_fault <= 1'b0;
    end else if (!cond) begin
      cnt      <= '0;
      ol_fault <= 1'b0;
    end else if (cnt >= blank_ticks) begin
      ol_fault <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign diag_n = ~(ol_fault | cutoff_flt | thermal_flt);

  AST_CLEAR_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |=> !ol_fault); // R4
  AST_CLEAR_ON_RECONNECT: assert property (@(posedge clk) disable iff (!rst_n)
    !ol_cmp |=> !ol_fault); // R5
  AST_RISE_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ol_fault) |-> $past(!cmd_on && ol_cmp)); // R2
  AST_DIAG_LOW_ON_OL: assert property (@(posedge clk) disable iff (!rst_n)
    ol_fault |-> !diag_n); // R7
  AST_FAULT_SETTLED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ol_fault |-> $stable(cnt)); // R2

endmodule

// File: tb/ol_blank_qual_bench.sv
module ol_blank_qual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_on = 1'b1;
  logic        ol_cmp = 1'b0;
  logic [15:0] blank_ticks = 16'd0;
  logic        cutoff_flt = 1'b0;
  logic        thermal_flt = 1'b0;
  logic        ol_fault, diag_n;
  int          vectors = 0;
  int          errs = 0;

  always #2.5 clk = ~clk;

  ol_blank_qual u_ol_blank_qual (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .ol_cmp(ol_cmp),
    .blank_ticks(blank_ticks), .cutoff_flt(cutoff_flt),
    .thermal_flt(thermal_flt), .ol_fault(ol_fault), .diag_n(diag_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cmd_on = 1'b1; ol_cmp = 1'b0;
    tick(); tick();
  endtask

  task automatic run_cond(input string req, input int n);
    cmd_on = 1'b0; ol_cmp = 1'b1; blank_ticks = 16'(n);
    for (int i = 1; i <= n; i++) begin
      tick();
      chk(req, ol_fault, 1'b0);
    end
    tick();
    chk(req, ol_fault, 1'b1);
    chk(req, diag_n, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", ol_fault, 1'b0);
    chk("R1", diag_n, 1'b1);
    cmd_on = 1'b0; ol_cmp = 1'b1;
    tick(); tick();
    chk("R1", ol_fault, 1'b0);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic t_basic();
    run_cond("R2", 5); idle();
    run_cond("R2", 12); idle();
  endtask

  task automatic t_zero();
    run_cond("R6", 0); idle();
  endtask

  task automatic t_glitch();
    cmd_on = 1'b0; ol_cmp = 1'b1; blank_ticks = 16'd4;
    for (int i = 0; i < 4; i++) tick();
    ol_cmp = 1'b0; tick();
    chk("R3", ol_fault, 1'b0);
    ol_cmp = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3", ol_fault, 1'b0);
    end
    tick();
    chk("R3", ol_fault, 1'b1);
    idle();
  endtask

  task automatic t_cmd_on();
    run_cond("R4", 3);
    cmd_on = 1'b1;
    tick();
    chk("R4", ol_fault, 1'b0);
    for (int i = 0; i < 10; i++) tick();
    chk("R4", ol_fault, 1'b0);
    chk("R4", diag_n, 1'b1);
    idle();
  endtask

  task automatic t_reconnect();
    run_cond("R5", 2);
    ol_cmp = 1'b0;
    tick();
    chk("R5", ol_fault, 1'b0);
    chk("R5", diag_n, 1'b1);
    idle();
  endtask

  task automatic t_cmd_fall();
    blank_ticks = 16'd6;
    cmd_on = 1'b1; ol_cmp = 1'b1;
    for (int i = 0; i < 20; i++) tick();
    cmd_on = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R8", ol_fault, 1'b0);
    end
    tick();
    chk("R8", ol_fault, 1'b1);
    idle();
  endtask

  task automatic t_shrink();
    cmd_on = 1'b0; ol_cmp = 1'b1; blank_ticks = 16'd20;
    for (int i = 0; i < 8; i++) tick();
    chk("R9", ol_fault, 1'b0);
    blank_ticks = 16'd3;
    tick();
    chk("R9", ol_fault, 1'b1);
    idle();
  endtask

  task automatic t_diag();
    cutoff_flt = 1'b1; #1;
    chk("R7", diag_n, 1'b0);
    cutoff_flt = 1'b0; thermal_flt = 1'b1; #1;
    chk("R7", diag_n, 1'b0);
    thermal_flt = 1'b0; #1;
    chk("R7", diag_n, 1'b1);
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_zero();
    t_glitch();
    t_cmd_on();
    t_reconnect();
    t_cmd_fall();
    t_shrink();
    t_diag();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule